// File: doc/BRIEF.md
# Prescaled 8-bit backlight PWM generator

This block drives one PWM line for a display backlight. An 8-bit counter advances on a prescaled tick and wraps every 256 ticks. The output is at its active level while the count is below an 8-bit duty value, so the high time is duty/256 of the period. The tick comes from one of two clock-enable strobes: a slow strobe or the system strobe. A power-of-two prescaler sits between that strobe and the counter.

Software controls the block through a small synchronous register bus. It writes the duty value, the prescaler select and the output polarity. It starts and stops the generator through separate write-one set and clear registers, then polls a status bit that confirms the change. New duty and prescaler values are held in a staging copy and take effect only at a counter wrap, so a running waveform never carries a broken period.

Top module: `bl_pwm`

## Requirements
- R1: While running, the period is 256 prescaled ticks. The output is active while the count is below the applied duty value. A duty of 0 gives no active time, and the largest duty of 255 gives 255/256.
- R2: The prescaler select field is bits 2:0 of the config register at address 4, and a prescaled tick occurs every 2^N selected ticks. A value of 7 behaves exactly as 6, giving a period of 16384 ticks.
- R3: Polarity is bit 4 of the config register. With 0 the active level is 1; with 1 the active level is 0. The inactive level, also driven while stopped, equals this bit. A polarity write takes effect at once.
- R4: Bit 0 of the general register at address 0 picks the counting strobe: 1 selects the system strobe and 0 selects the slow strobe.
- R5: Writing bit 0 = 1 to address 1 starts the generator, and writing bit 0 = 1 to address 2 stops it. A write with bit 0 = 0 to either address changes nothing.
- R6: The status register at address 3 has a run bit at bit 0. After a write at clock edge k that starts or stops the generator, this bit takes its new value at edge k+2.
- R7: Duty (config bits 15:8) and prescaler writes go to a staging copy. While running, the staging copy is applied only when the count wraps from 255 to 0; while stopped, it is applied at once. A read returns the staging copy immediately.
- R8: While stopped, the counter and prescaler are held at zero. When started with a nonzero duty, the output is active from the first clock after the start write.
- R9: Reads are combinational. Address 4 returns duty in 15:8, polarity in 4 and the prescaler select in 2:0, with all other bits 0. Address 0 returns the strobe select in bit 0. Addresses 1 and 2 read as 0.
- R10: After reset every register is 0, the generator is stopped, status reads 0 and the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow counting strobe, one clock wide |
| sys_tick | input | 1 | System counting strobe, one clock wide |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe for one clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pwm_out | output | 1 | PWM output line |

## Verification
The status-latency properties assume that a start write is not followed within two clocks by a stop write, and the reverse. The bench keeps this by leaving at least one idle bus cycle after every write and at least several cycles between any start and stop. The staging property assumes that configuration changes made while running matter only at a wrap. The stimulus therefore waits more than one full period after each change before it measures, and measures either over whole periods or between rising active edges.

// File: rtl/bl_pwm.sv
module bl_pwm #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int CNT_W       = 8,
  parameter int PS_W        = 3,
  parameter int PS_MAX      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              sys_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  localparam int PRE_W    = PS_MAX;
  localparam int DUTY_LSB = 8;
  localparam int POL_BIT  = 4;
  localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(4);

  logic                   sel_sys_q, pol_q, run_q;
  logic [CNT_W-1:0]       duty_sh, duty_q, cnt_q;
  logic [PS_W-1:0]        ps_sh, ps_q, ps_eff;
  logic [PRE_W-1:0]       pre_q, pre_mask;
  logic [SYNC_STAGES-1:0] stat_pipe;
  logic                   status_w;

  wire wr_gen = bus_we && (bus_addr == A_GEN);
  wire wr_en  = bus_we && (bus_addr == A_EN);
  wire wr_dis = bus_we && (bus_addr == A_DIS);
  wire wr_cfg = bus_we && (bus_addr == A_CFG);
  wire unused_wdata = ^bus_wdata;

  wire tick  = sel_sys_q ? sys_tick : slow_tick;
  assign ps_eff   = (ps_sh > PS_W'(PS_MAX)) ? PS_W'(PS_MAX) : ps_sh;
  assign pre_mask = ~({PRE_W{1'b1}} << ps_q);
  wire ptick = run_q && tick && (pre_q == pre_mask);
  wire wrap  = ptick && (cnt_q == {CNT_W{1'b1}});

  assign status_w = stat_pipe[SYNC_STAGES-1];
  assign pwm_out  = (run_q && (cnt_q < duty_q)) ^ pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sys_q <= 1'b0;
      pol_q     <= 1'b0;
      run_q     <= 1'b0;
      duty_sh   <= '0;
      duty_q    <= '0;
      ps_sh     <= '0;
      ps_q      <= '0;
      cnt_q     <= '0;
      pre_q     <= '0;
      stat_pipe <= '0;
    end else begin
      if (wr_gen) sel_sys_q <= bus_wdata[0];
      if (wr_cfg) begin
        duty_sh <= bus_wdata[DUTY_LSB +: CNT_W];
        pol_q   <= bus_wdata[POL_BIT];
        ps_sh   <= bus_wdata[PS_W-1:0];
      end
      if (wr_dis && bus_wdata[0])     run_q <= 1'b0;
      else if (wr_en && bus_wdata[0]) run_q <= 1'b1;

      stat_pipe <= {stat_pipe[SYNC_STAGES-2:0], run_q};

      if (!run_q) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick) begin
        pre_q <= (pre_q == pre_mask) ? '0 : pre_q + 1'b1;
        if (ptick) cnt_q <= cnt_q + 1'b1;
      end

      if (!run_q || wrap) begin
        duty_q <= duty_sh;
        ps_q   <= ps_eff;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_GEN:  bus_rdata[0] = sel_sys_q;
      A_STAT: bus_rdata[0] = status_w;
      A_CFG: begin
        bus_rdata[DUTY_LSB +: CNT_W] = duty_sh;
        bus_rdata[POL_BIT]           = pol_q;
        bus_rdata[PS_W-1:0]          = ps_sh;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8,
  parameter int PS_W   = 3,
  parameter int PS_MAX = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              wd0,
  input logic              status_w,
  input logic              pwm_out,
  input logic              run_q,
  input logic              pol_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  duty_q,
  input logic [PS_W-1:0]   ps_q,
  input logic              wrap
);
  wire en_one  = bus_we && (bus_addr == ADDR_W'(1)) && wd0;
  wire dis_one = bus_we && (bus_addr == ADDR_W'(2)) && wd0;
  wire en_zero = bus_we && (bus_addr == ADDR_W'(1)) && !wd0;

  a_r6_status_on: assert property (@(posedge clk) disable iff (!rst_n)
    en_one |=> ##2 status_w);
  a_r6_status_off: assert property (@(posedge clk) disable iff (!rst_n)
    dis_one |=> ##2 !status_w);
  a_r5_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en_zero && !run_q) |=> !run_q);
  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (cnt_q == '0));
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (pwm_out == pol_q));
  a_r1_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && duty_q == '0) |-> (pwm_out == pol_q));
  a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$past(wrap)) |-> ($stable(duty_q) && $stable(ps_q)));
  a_r2_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    ps_q <= PS_W'(PS_MAX));
endmodule

bind bl_pwm bl_pwm_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PS_W(PS_W), .PS_MAX(PS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .wd0(bus_wdata[0]),
  .status_w(status_w), .pwm_out(pwm_out), .run_q(run_q), .pol_q(pol_q),
  .cnt_q(cnt_q), .duty_q(duty_q), .ps_q(ps_q), .wrap(wrap)
);

// File: tb/bl_pwm_test.sv
module bl_pwm_test;
  logic clk = 0, rst_n = 0;
  logic slow_tick, sys_tick;
  logic [2:0] addr = 0;
  logic we = 0;
  logic [31:0] wdata = 0, rdata;
  logic pwm_out;
  logic [1:0] div = 0;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  string req_q[$];
  int exp_q[$], act_q[$];

  always #10 clk = ~clk;
  always @(negedge clk) div <= div + 1'b1;
  assign slow_tick = (div == 2'd3);
  assign sys_tick  = 1'b1;

  bl_pwm uut (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sys_tick(sys_tick),
              .bus_addr(addr), .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
              .pwm_out(pwm_out));

  task automatic check(input string r, input int a, input int e);
    req_q.push_back(r); exp_q.push_back(e); act_q.push_back(a);
  endtask

  always @(negedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      string r; int a, e;
      r = req_q.pop_front(); a = act_q.pop_front(); e = exp_q.pop_front();
      n_vec++;
      if (a != e) begin
        n_bad++;
        $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", r, a, a, e, e);
      end
    end
  end

  task automatic step; @(negedge clk); #1; endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0; #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic count_active(input int n, input logic pol, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin step(); if (pwm_out != pol) c++; end
  endtask

  task automatic sync_rise(input logic pol);
    int g = 0;
    while (pwm_out != pol && g < 70000) begin step(); g++; end
    while (pwm_out == pol && g < 70000) begin step(); g++; end
  endtask

  task automatic meas_period(input logic pol, output int p);
    sync_rise(pol);
    p = 0;
    while (pwm_out != pol && p < 70000) begin step(); p++; end
    while (pwm_out == pol && p < 70000) begin step(); p++; end
  endtask

  initial begin
    #(150000 * 20);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c, p, hi;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R10 reset state
    check("R10 out", pwm_out, 0);
    rd(3, d); check("R10 status", d, 0);
    rd(4, d); check("R10 cfg", d, 0);
    rd(0, d); check("R10 gen", d, 0);

    wr(4, 32'h0000_4000);
    rd(4, d); check("R9 cfg readback", d, 32'h4000);
    wr(0, 1);
    rd(0, d); check("R9 gen readback", d, 1);
    wr(1, 1);
    check("R8 active on first cycle", pwm_out, 1);
    rd(3, d); check("R6 status k+1", d[0], 0);
    step(); rd(3, d); check("R6 status before k+2", d[0], 0);
    step(); rd(3, d); check("R6 status at k+2", d[0], 1);

    count_active(256, 0, c); check("R1 duty 64 high", c, 64);
    meas_period(0, p); check("R1 period", p, 256);

    wr(4, 32'h0000_0000); repeat (600) step();
    count_active(256, 0, c); check("R1 duty 0", c, 0);
    wr(4, 32'h0000_FF00); repeat (600) step();
    count_active(256, 0, c); check("R1 duty 255", c, 255);

    wr(4, 32'h0000_8002); repeat (3000) step();
    count_active(1024, 0, c); check("R2 ps2 high", c, 512);
    meas_period(0, p); check("R2 ps2 period", p, 1024);

    wr(4, 32'h0000_1007); repeat (1100) step();
    meas_period(0, p); check("R2 ps7 as 6 period", p, 16384);
    rd(4, d); check("R9 cfg ps7 readback", d, 32'h1007);

    wr(4, 32'h0000_4000); repeat (16500) step();
    wr(0, 0); repeat (50) step();
    meas_period(0, p); check("R4 slow period", p, 1024);
    count_active(1024, 0, c); check("R4 slow high", c, 256);

    wr(0, 1); wr(4, 32'h0000_4010); repeat (2000) step();
    count_active(256, 1, c); check("R3 inverted active", c, 64);
    count_active(256, 0, c); check("R3 high cycles inverted", c, 192);

    wr(4, 32'h0000_4000); repeat (600) step();
    // R7 mid-period write keeps current pulse
    sync_rise(0);
    hi = 1;
    while (hi < 1000) begin
      @(negedge clk);
      if (hi == 5) begin addr = 4; wdata = 32'h0000_C800; we = 1; end
      else we = 0;
      #1;
      if (pwm_out) hi++; else break;
    end
    we = 0;
    check("R7 current pulse kept", hi, 64);
    rd(4, d); check("R7 staged readback", d, 32'hC800);
    sync_rise(0);
    hi = 1;
    while (hi < 1000) begin step(); if (pwm_out) hi++; else break; end
    check("R7 new pulse at wrap", hi, 200);

    wr(2, 0); repeat (5) step();
    rd(3, d); check("R5 zero disable write", d[0], 1);
    meas_period(0, p); check("R5 still running", p, 256);

    wr(2, 1);
    check("R3 stop to inactive", pwm_out, 0);
    rd(3, d); check("R6 stop status k+1", d[0], 1);
    step(); rd(3, d); check("R6 stop before k+2", d[0], 1);
    step(); rd(3, d); check("R6 stop at k+2", d[0], 0);

    wr(1, 0); repeat (5) step();
    rd(3, d); check("R5 zero enable write", d[0], 0);
    count_active(300, 0, c); check("R5 stays stopped", c, 0);

    wr(4, 32'h0000_4010);
    count_active(50, 0, c); check("R3 idle level pol1", c, 50);

    wr(4, 32'hFFFF_FFFF);
    rd(4, d); check("R9 cfg masking", d, 32'h0000_FF17);
    rd(1, d); check("R9 enable reads 0", d, 0);
    rd(2, d); check("R9 disable reads 0", d, 0);

    wr(4, 32'h0000_0A00);
    wr(1, 1);
    check("R8 restart from zero", pwm_out, 1);
    count_active(256, 0, c); check("R7 stopped load immediate", c, 10);

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule